// File: doc/BRIEF.md
# Configurable Scalar Recoding Unit

This block turns a secret scalar into a stream of signed digits for a point-multiplication controller. The scalar sits in a word-addressed memory. The unit reads it one 32-bit word at a time through a read port with a fixed one-cycle latency. For each request it returns one digit in sign-magnitude form, and it flags the final digit of the scalar. A mode value sampled at start selects one of four recodings: plain binary, which is emitted most-significant digit first; or a signed non-adjacent form with window width 2, 3 or 4, which is emitted least-significant digit first.

In the signed modes, a negative digit adds a carry into the next higher bit of the scalar. The unit holds the unconsumed bits in a two-word window and keeps that carry across word boundaries. The carry can push the top of the scalar up by one position, so the signed modes always produce one digit more than the scalar width. Every recoding sums back to the original scalar. The controller can stall for as long as it likes: the unit produces nothing until the controller asks for it.

Top module: `srec_recoder`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `word_rd`, `digit_valid` and `digit_last` are all 0.
- R2: A start pulse while idle samples `mode`: 0 is binary, 1 is width-2 signed form, 2 is width-3, 3 is width-4. The mode stays fixed until the run ends, whatever `mode` does in the meantime.
- R3: `word_rd` reads the word at `word_addr`, and that word is on `word_data` in the following cycle. Binary mode reads the addresses from KEY_BITS/32-1 down to 0. The signed modes read them from 0 upward. Each word is read exactly once, and two reads are never issued in consecutive cycles.
- R4: Binary mode emits exactly KEY_BITS digits, most-significant first. Each digit has `digit_neg`=0 and a magnitude of 0 or 1.
- R5: The signed modes emit exactly KEY_BITS+1 digits, least-significant first. The sum of d_i·2^i over those digits equals the scalar.
- R6: A digit is given as `digit_neg` (1 means negative) plus a 3-bit `digit_mag`. In the signed modes, every nonzero digit has an odd magnitude below 2^(λ-1), where λ is the window width.
- R7: In the signed mode of width λ, no λ consecutive digits hold more than one nonzero digit.
- R8: A carry that a negative digit creates moves into the next word. For a scalar of 2^32-1 in width-3 mode, digit 0 is -1, digit 32 is +1 and all other digits are 0.
- R9: The extra top position holds the final carry. For an all-ones scalar in a signed mode, digit 0 is -1, digit KEY_BITS is +1 and all other digits are 0.
- R10: Each `next_digit` accepted while no request is outstanding yields exactly one single-cycle `digit_valid` pulse, one or more cycles later. A `next_digit` that arrives while a request is still outstanding is ignored. No digit appears without a request.
- R11: `digit_last` is high together with `digit_valid` on the final digit only, and `busy` is 0 from that cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a recoding run; honoured only while idle |
| mode | input | 2 | Recoding select, sampled on start |
| busy | output | 1 | A run is in progress |
| word_rd | output | 1 | Scalar memory read strobe |
| word_addr | output | ADDR_W | Scalar word address |
| word_data | input | WORD_W | Read data, valid the cycle after `word_rd` |
| next_digit | input | 1 | Request for the next digit |
| digit_valid | output | 1 | One-cycle pulse: a digit is presented |
| digit_neg | output | 1 | Sign of the digit, 1 for negative |
| digit_mag | output | 3 | Magnitude of the digit |
| digit_last | output | 1 | Marks the final digit of the run |

## Verification
The bench rebuilds the scalar from every digit stream. It uses scalars whose carries run through whole words: all ones, a single all-ones low word, and pseudo-random values. A unit that dropped the carry at a word edge, or lost the top carry position, would rebuild a value that is off by a power of two. The bench checks the read address order and the spacing of reads, so a unit that read in the wrong direction would fail. It also checks the digit window property and the magnitude bounds, so a unit that mis-rounded the residue or skipped the forced zeros after a nonzero digit would fail. The bench holds back requests, holds the request line high for an extra cycle, and changes `mode` during a run. A unit that ran ahead of the controller, answered twice or changed recoding mid-run would show an extra digit or a wrong count.

// File: rtl/srec_pkg.sv
// Shared types for the scalar recoding unit.
package srec_pkg;

    // Recoding selection; the encoding is visible on the mode port.
    typedef enum logic [1:0] {
        RM_BIN  = 2'd0,
        RM_NAF2 = 2'd1,
        RM_NAF3 = 2'd2,
        RM_NAF4 = 2'd3
    } rmode_e;

    // Widest digit window the encoder looks at.
    localparam int WIN_MAX = 4;

    // Window width for a mode; binary consumes one bit per digit.
    function automatic logic [2:0] window_of(rmode_e m);
        case (m)
            RM_NAF2: return 3'd2;
            RM_NAF3: return 3'd3;
            RM_NAF4: return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/srec_fetch.sv
// Scalar word fetcher.
// Issues one read at a time to a memory with one-cycle read latency,
// walking the word addresses upward or downward. Assumes start is only
// raised while no run is active.
module srec_fetch #(
    parameter int NUM_WORDS = 8,
    parameter int ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              descending,
    input  logic              want,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              arrive,
    output logic              drained
);
    localparam int CNT_W = $clog2(NUM_WORDS + 1);

    logic [ADDR_W-1:0] idx_q;
    logic [CNT_W-1:0]  left_q;
    logic              inflight_q;

    assign rd_en   = want && (left_q != '0) && !inflight_q;
    assign rd_addr = descending ? (ADDR_W'(NUM_WORDS - 1) - idx_q) : idx_q;
    assign arrive  = inflight_q;
    assign drained = (left_q == '0) && !inflight_q;

    // Track the next word index, the words still to read and the read in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            left_q     <= '0;
            inflight_q <= 1'b0;
        end else if (start) begin
            idx_q      <= '0;
            left_q     <= CNT_W'(NUM_WORDS);
            inflight_q <= 1'b0;
        end else begin
            inflight_q <= rd_en;
            if (rd_en) begin
                idx_q  <= idx_q + ADDR_W'(1);
                left_q <= left_q - CNT_W'(1);
            end
        end
    end

    assert_read_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

endmodule

// File: rtl/srec_window.sv
// Bit window over the scalar.
// Holds up to two words of unconsumed scalar bits, least significant
// at bit 0. A consumed group shifts out while a fetched word is appended
// above the bits that remain. Once the scalar is exhausted, zeros shift in.
module srec_window #(
    parameter int WORD_W = 32,
    parameter int LOW_W  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clear,
    input  logic                            shift_en,
    input  logic [2:0]                      shift_amt,
    input  logic                            load_en,
    input  logic [WORD_W-1:0]               load_word,
    output logic [LOW_W-1:0]                low_bits,
    output logic [$clog2(2*WORD_W+1)-1:0]   fill
);
    localparam int BUF_W  = 2 * WORD_W;
    localparam int FILL_W = $clog2(BUF_W + 1);

    logic [BUF_W-1:0]  buf_q, shifted, appended;
    logic [FILL_W-1:0] fill_q, kept_fill;

    // Remove the consumed bits and place any arriving word above the rest.
    always_comb begin
        if (shift_en) begin
            shifted   = buf_q >> shift_amt;
            kept_fill = (fill_q >= FILL_W'(shift_amt)) ? (fill_q - FILL_W'(shift_amt)) : '0;
        end else begin
            shifted   = buf_q;
            kept_fill = fill_q;
        end
        appended = load_en ? (BUF_W'(load_word) << kept_fill) : '0;
    end

    // Register the window contents and how many valid bits it holds.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            buf_q  <= '0;
            fill_q <= '0;
        end else begin
            buf_q  <= shifted | appended;
            fill_q <= kept_fill + (load_en ? FILL_W'(WORD_W) : '0);
        end
    end

    assign low_bits = buf_q[LOW_W-1:0];
    assign fill     = fill_q;

    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FILL_W'(BUF_W));

endmodule

// File: rtl/srec_digit_enc.sv
// Digit encoder.
// From the lowest window bits and the incoming carry, forms the next digit,
// how many bit positions it consumes and the carry it leaves. The signed
// modes take the odd residue modulo 2^w in the symmetric range; an even
// position gives a zero digit and passes the carry up one bit.
module srec_digit_enc
    import srec_pkg::*;
(
    input  rmode_e             mode,
    input  logic [WIN_MAX-1:0] bits,
    input  logic               carry_in,
    output logic               neg,
    output logic [2:0]         mag,
    output logic [2:0]         step,
    output logic               carry_out
);
    logic [2:0] lam;
    logic [4:0] full, half, sum, resid;

    // Combinational digit selection for the active mode.
    always_comb begin
        lam       = window_of(mode);
        full      = 5'd1 << lam;
        half      = full >> 1;
        sum       = {1'b0, bits} + {4'b0000, carry_in};
        resid     = sum & (full - 5'd1);
        neg       = 1'b0;
        mag       = 3'd0;
        step      = 3'd1;
        carry_out = 1'b0;
        if (mode == RM_BIN) begin
            mag = {2'b00, bits[0]};
        end else if (!resid[0]) begin
            carry_out = bits[0] & carry_in;
        end else begin
            step = lam;
            if (resid >= half) begin
                neg       = 1'b1;
                mag       = 3'(full - resid);
                carry_out = 1'b1;
            end else begin
                mag = 3'(resid);
            end
        end
    end

endmodule

// File: rtl/srec_recoder.sv
// Scalar recoding unit, top level.
// Reads the scalar word by word and hands out one signed digit per request.
// Binary goes most-significant first; the signed window modes go
// least-significant first and add one extra top position for the final carry.
// Assumes the memory returns data the cycle after a read strobe.
module srec_recoder
    import srec_pkg::*;
#(
    parameter  int KEY_BITS  = 256,
    parameter  int WORD_W    = 32,
    localparam int NUM_WORDS = KEY_BITS / WORD_W,
    localparam int ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    output logic              busy,
    output logic              word_rd,
    output logic [ADDR_W-1:0] word_addr,
    input  logic [WORD_W-1:0] word_data,
    input  logic              next_digit,
    output logic              digit_valid,
    output logic              digit_neg,
    output logic [2:0]        digit_mag,
    output logic              digit_last
);
    localparam int FILL_W = $clog2(2 * WORD_W + 1);
    localparam int POS_W  = $clog2(KEY_BITS + 2);

    rmode_e            mode_q;
    logic              busy_q, carry_q, req_q;
    logic [1:0]        zrun_q;
    logic [POS_W-1:0]  pos_q;
    logic              dv_q, neg_q, last_q;
    logic [2:0]        mag_q;

    logic [2:0]        lam, need;
    logic [3:0]        half_lim;
    logic              begin_run, bits_ready, emit, at_end, shift_en;
    logic              arrive, drained, want;
    logic [FILL_W-1:0] fill;
    logic [WIN_MAX-1:0] low_bits;
    logic [WORD_W-1:0] word_rev, load_word;
    logic              enc_neg, enc_carry;
    logic [2:0]        enc_mag, enc_step;
    logic [POS_W-1:0]  last_pos;

    assign lam        = window_of(mode_q);
    assign need       = (mode_q == RM_BIN) ? 3'd1 : lam;
    assign half_lim   = 4'd1 << (lam - 3'd1);
    assign begin_run  = start && !busy_q;
    assign want       = busy_q && (fill <= FILL_W'(WORD_W));
    assign bits_ready = drained || (fill >= FILL_W'(need));
    assign emit       = busy_q && req_q && ((zrun_q != 2'd0) || bits_ready);
    assign last_pos   = (mode_q == RM_BIN) ? POS_W'(KEY_BITS - 1) : POS_W'(KEY_BITS);
    assign at_end     = (pos_q == last_pos);
    assign shift_en   = emit && (zrun_q == 2'd0);

    // Binary runs most-significant first, so each word enters the window reversed.
    for (genvar b = 0; b < WORD_W; b++) begin : g_rev
        assign word_rev[b] = word_data[WORD_W-1-b];
    end
    assign load_word = (mode_q == RM_BIN) ? word_rev : word_data;

    srec_fetch #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .start(begin_run),
        .descending(mode_q == RM_BIN), .want(want),
        .rd_en(word_rd), .rd_addr(word_addr), .arrive(arrive), .drained(drained)
    );

    srec_window #(.WORD_W(WORD_W), .LOW_W(WIN_MAX)) u_window (
        .clk(clk), .rst_n(rst_n), .clear(begin_run),
        .shift_en(shift_en), .shift_amt(enc_step),
        .load_en(arrive), .load_word(load_word),
        .low_bits(low_bits), .fill(fill)
    );

    srec_digit_enc u_enc (
        .mode(mode_q), .bits(low_bits), .carry_in(carry_q),
        .neg(enc_neg), .mag(enc_mag), .step(enc_step), .carry_out(enc_carry)
    );

    // Run control: latch the mode, accept requests, emit digits and run the zero gaps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            mode_q  <= RM_BIN;
            carry_q <= 1'b0;
            zrun_q  <= 2'd0;
            pos_q   <= '0;
            req_q   <= 1'b0;
            dv_q    <= 1'b0;
            neg_q   <= 1'b0;
            mag_q   <= 3'd0;
            last_q  <= 1'b0;
        end else begin
            dv_q   <= emit;
            last_q <= emit && at_end;
            if (begin_run) begin
                busy_q  <= 1'b1;
                mode_q  <= rmode_e'(mode);
                carry_q <= 1'b0;
                zrun_q  <= 2'd0;
                pos_q   <= '0;
                req_q   <= 1'b0;
            end else if (busy_q) begin
                if (emit) begin
                    req_q <= 1'b0;
                    pos_q <= pos_q + POS_W'(1);
                    if (at_end) busy_q <= 1'b0;
                    if (zrun_q != 2'd0) begin
                        zrun_q <= zrun_q - 2'd1;
                        neg_q  <= 1'b0;
                        mag_q  <= 3'd0;
                    end else begin
                        neg_q   <= enc_neg;
                        mag_q   <= enc_mag;
                        carry_q <= enc_carry;
                        if (enc_mag != 3'd0 && mode_q != RM_BIN)
                            zrun_q <= 2'(lam - 3'd1);
                    end
                end else if (next_digit && !req_q) begin
                    req_q <= 1'b1;
                end
            end
        end
    end

    assign busy        = busy_q;
    assign digit_valid = dv_q;
    assign digit_neg   = neg_q;
    assign digit_mag   = mag_q;
    assign digit_last  = last_q;

    assert_bin_digit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        digit_valid && mode_q == RM_BIN |-> !digit_neg && digit_mag <= 3'd1);

    assert_odd_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        digit_valid && mode_q != RM_BIN && digit_mag != 3'd0
            |-> digit_mag[0] && ({1'b0, digit_mag} < half_lim));

    assert_zero_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        digit_valid && digit_mag != 3'd0 |-> $past(zrun_q) == 2'd0);

    assert_requested_R10: assert property (@(posedge clk) disable iff (!rst_n)
        digit_valid |-> $past(req_q));

    assert_last_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        digit_last |-> digit_valid && !busy);

endmodule

// File: tb/srec_recoder_bench.sv
// Directed bench for the scalar recoding unit.
module srec_recoder_bench;
    localparam int K  = 256;
    localparam int W  = 32;
    localparam int NW = K / W;
    localparam int AW = $clog2(NW);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, next_digit = 1'b0;
    logic [1:0] mode = 2'd0;
    logic busy, word_rd, digit_valid, digit_neg, digit_last;
    logic [2:0] digit_mag;
    logic [AW-1:0] word_addr;
    logic [W-1:0] word_data = '0;
    logic [W-1:0] mem [NW];

    int total = 0, bad = 0;
    int dig [K+1];
    int ndig, nlast;
    bit done;
    int rd_log [2*NW];
    int rd_cnt, rd_b2b;
    bit mon_on = 1'b0, prev_rd = 1'b0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    srec_recoder #(.KEY_BITS(K), .WORD_W(W)) u_srec_recoder (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy),
        .word_rd(word_rd), .word_addr(word_addr), .word_data(word_data),
        .next_digit(next_digit), .digit_valid(digit_valid), .digit_neg(digit_neg),
        .digit_mag(digit_mag), .digit_last(digit_last)
    );

    always #5 clk = ~clk;

    // Scalar memory with one-cycle read latency.
    always @(posedge clk) if (word_rd) word_data <= mem[word_addr];

    // Log read addresses and spot back-to-back reads.
    always @(negedge clk) begin
        if (mon_on && word_rd) begin
            if (rd_cnt < 2*NW) rd_log[rd_cnt] = int'(word_addr);
            rd_cnt++;
            if (prev_rd) rd_b2b++;
        end
        prev_rd = word_rd;
    end

    task automatic check(bit ok, string req, string what, logic [K+2:0] act, logic [K+2:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [K-1:0] rand_key();
        logic [K-1:0] v;
        for (int c = 0; c < K/64; c++) begin
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >> 7);
            seed = seed ^ (seed << 17);
            v[c*64 +: 64] = seed;
        end
        return v;
    endfunction

    task automatic take_digit();
        if (ndig <= K) dig[ndig] = digit_neg ? -int'(digit_mag) : int'(digit_mag);
        ndig++;
        if (digit_last) begin nlast++; done = 1'b1; end
    endtask

    // One full run: optional stall and double-length first request, then all digits and checks.
    task automatic run_scalar(input logic [1:0] m, input logic [K-1:0] kv, input int stall, input bit hold2);
        int lam, expn, cnt, w;
        logic signed [K+2:0] acc;
        for (int j = 0; j < NW; j++) mem[j] = kv[j*W +: W];
        rd_cnt = 0; rd_b2b = 0; ndig = 0; nlast = 0; done = 1'b0; mon_on = 1'b1;
        @(negedge clk); mode = m; start = 1'b1;
        @(negedge clk); start = 1'b0; mode = ~m;   // R2: later mode changes must not matter
        if (stall > 0) begin
            cnt = 0;
            repeat (stall) begin @(negedge clk); if (digit_valid) cnt++; end
            check(cnt == 0, "R10", "digits without request", cnt, 0);
        end
        if (hold2) begin
            cnt = 0; next_digit = 1'b1;
            for (int c = 0; c < 14; c++) begin
                @(negedge clk);
                if (c == 1) next_digit = 1'b0;
                if (digit_valid) begin cnt++; take_digit(); end
            end
            check(cnt == 1, "R10", "pulses for held request", cnt, 1);
        end
        while (!done && ndig < K + 2) begin
            next_digit = 1'b1; @(negedge clk); next_digit = 1'b0;
            w = 0;
            while (!digit_valid && w < 100) begin @(negedge clk); w++; end
            if (w >= 100) begin check(1'b0, "R10", "digit timeout", ndig, 0); break; end
            take_digit();
        end
        repeat (4) @(negedge clk);
        mon_on = 1'b0;
        lam  = (m == 2'd0) ? 1 : int'(m) + 1;
        expn = (m == 2'd0) ? K : K + 1;
        check(ndig == expn, (m == 2'd0) ? "R4" : "R5", "digit count", ndig, expn);
        check(nlast == 1 && !busy, "R11", "single last flag then idle", nlast, 1);
        check(rd_cnt == NW && rd_b2b == 0, "R3", "read count and spacing", rd_cnt, NW);
        for (int j = 0; j < NW && j < rd_cnt; j++) begin
            int ea = (m == 2'd0) ? NW - 1 - j : j;
            check(rd_log[j] == ea, "R3", "read address order", rd_log[j], ea);
        end
        acc = '0;
        if (m == 2'd0) begin
            for (int i = 0; i < ndig && i < K; i++) acc = acc * 2 + dig[i];
            for (int i = 0; i < ndig && i < K; i++)
                if (dig[i] < 0 || dig[i] > 1) begin check(1'b0, "R4", "binary digit range", dig[i], 1); break; end
        end else begin
            for (int i = ((ndig < K + 1) ? ndig : K + 1) - 1; i >= 0; i--) acc = acc * 2 + dig[i];
            for (int i = 0; i < ndig && i <= K; i++) begin
                if (dig[i] != 0) begin
                    int a = (dig[i] < 0) ? -dig[i] : dig[i];
                    if (a % 2 == 0 || a >= (1 << (lam - 1))) begin
                        check(1'b0, "R6", "digit magnitude", a, 1 << (lam - 1)); break;
                    end
                    for (int q = i + 1; q < i + lam && q <= K && q < ndig; q++)
                        if (dig[q] != 0) begin check(1'b0, "R7", "window density", q, i); break; end
                end
            end
        end
        check(acc == $signed({3'b000, kv}), (m == 2'd0) ? "R4" : "R5", "rebuilt scalar", acc, {3'b000, kv});
    endtask

    task automatic t_reset();
        check(!busy && !word_rd && !digit_valid && !digit_last, "R1", "reset outputs",
              {busy, word_rd, digit_valid, digit_last}, 0);
    endtask

    task automatic t_zero();
        for (int m = 0; m < 4; m++) begin
            run_scalar(2'(m), '0, 0, 1'b0);
            for (int i = 0; i < ndig && i <= K; i++)
                if (dig[i] != 0) begin check(1'b0, "R5", "zero scalar digit", dig[i], 0); break; end
        end
    endtask

    task automatic t_ones();
        for (int m = 1; m < 4; m++) begin
            run_scalar(2'(m), '1, 0, 1'b0);
            check(dig[0] == -1 && dig[K] == 1, "R9", "all-ones end digits", dig[K], 1);
        end
        run_scalar(2'd0, '1, 0, 1'b0);
    endtask

    task automatic t_boundary();
        logic [K-1:0] kv = '0;
        kv[W-1:0] = '1;
        run_scalar(2'd2, kv, 0, 1'b0);
        check(dig[0] == -1 && dig[W] == 1, "R8", "carry into next word", dig[W], 1);
    endtask

    task automatic t_random();
        for (int r = 0; r < 2; r++)
            for (int m = 0; m < 4; m++) run_scalar(2'(m), rand_key(), 0, 1'b0);
    endtask

    task automatic t_stall();
        run_scalar(2'd3, rand_key(), 20, 1'b0);
    endtask

    task automatic t_hold();
        run_scalar(2'd1, rand_key(), 0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_ones();
        t_boundary();
        t_random();
        t_stall();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule